// File: doc/BRIEF.md
# Converter Serial Result Port with Cascade Input

This block is the serial output side of a 16-bit converter, acting as a slave to an external host clock. A conversion engine model presents a result word and a busy flag. The host pulls chip select and read enable low and toggles a serial clock in bursts. The port shifts the result out MSB first. The host samples each bit on the rising serial clock edge, and the port moves to the next bit on the falling edge. All serial inputs are sampled by the system clock, and serial clock edges are found after a short synchronizer.

A mode pin selects between two read rules. In read-after-conversion mode the word becomes readable when busy drops. A cascade input lets several ports share one host line: bits arriving on that input are captured on the rising serial edge and follow the port's own word. In read-during-conversion mode the host reads the previous word while the next conversion runs, the cascade input is ignored, and a one-cycle error pulse marks a read left unfinished when the conversion ends.

The data path is a bit-serial slave, so it has no valid/ready pair. Pacing comes only from the host's serial clock: the port never stalls the host, and the host may pause between serial pulses for as long as it likes.

Top module: `adc_serial_rd`

## Requirements
- R1: After reset, `sdout_en` and `rd_err` are 0 and `sdout` is 0.
- R2: While `cs_n` and `rd_n` are both low, the word is presented MSB first and advances by one bit per falling `sclk` edge; the host reads a bit before each rising edge. `sclk` pulses while `rd_n` is high do not advance the word.
- R3: `sdout_en` is 1 exactly while `cs_n` is low, and `sdout` is 0 whenever `sdout_en` is 0.
- R4: `mode` = 0 selects read-after-conversion. In this mode a result is taken when `busy` falls, and shifting cannot begin while `busy` is high. A read already begun (at least one bit shifted) may continue while `busy` is high.
- R5: In `mode` 0, a falling `busy` while `cs_n` is low and at least one bit has been shifted does not disturb the word being read. The new result is kept and becomes the readable word when `cs_n` next rises.
- R6: In `mode` 0, `chain_in` is captured on each rising `sclk` edge during a read and shifted in behind the word. Two cascaded ports therefore deliver 32 bits, downstream word first, with no gap.
- R7: `mode` = 1 selects read-during-conversion. In this mode `chain_in` is ignored, and bits clocked out after the 16-bit word are 0.
- R8: In `mode` 1, `rd_err` pulses high for exactly one clock when `busy` falls with `cs_n` low after 1 to 15 bits have been shifted. It stays low after a complete read, and it never pulses in `mode` 0.
- R9: A rise of `cs_n` abandons the read. The next read starts again from the MSB of the readable word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | 0 = read after conversion, 1 = read during conversion |
| busy | input | 1 | Conversion in progress flag from the engine model |
| result | input | DATA_W | Conversion result, taken on falling `busy` |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read enable |
| sclk | input | 1 | Host serial clock (discontinuous) |
| chain_in | input | 1 | Cascade input from the upstream port |
| sdout | output | 1 | Serial data out |
| sdout_en | output | 1 | Output drive enable (low means high impedance) |
| rd_err | output | 1 | One-cycle incomplete-read pulse |

## Verification
Two ports are cascaded with a common busy and serial clock. Random word pairs are read as 32-bit streams, which separates correct MSB-first order and downstream-first cascading from swapped or reversed bits. Directed patterns pulse `sclk` with read enable high, read while busy is high before any shift, end a conversion in the middle of a read, and abandon a read early. Each of these shows whether gating, deferred loading and restart behave as required. In read-during mode a full read is compared with a short read, which separates a correct error pulse from one that is missing or spurious, and a cascade input carrying data shows whether it is ignored.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic {
    RD_AFTER  = 1'b0,
    RD_DURING = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/sclk_edge.sv
module sclk_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= sclk;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
  assign fall = ~sync_q[STAGES-1] & last_q;
endmodule

// File: rtl/rd_load_ctrl.sv
module rd_load_ctrl
  import adc_rd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rd_mode_e          mode,
  input  logic              busy,
  input  logic [DATA_W-1:0] result,
  input  logic              cs_n,
  input  logic [CNT_W-1:0]  bit_cnt,
  output logic              load_en,
  output logic [DATA_W-1:0] load_data,
  output logic              rd_err
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  logic              busy_q, cs_q;
  logic              pend_vld;
  logic [DATA_W-1:0] pend_q, word_q;
  logic              busy_fall, cs_rise, read_open, hold_off, take_new;
  logic              err_d, err_q;

  assign busy_fall = busy_q & ~busy;
  assign cs_rise   = ~cs_q & cs_n;
  assign read_open = ~cs_n & (bit_cnt != '0);
  assign hold_off  = (mode == RD_AFTER) & read_open;
  assign take_new  = busy_fall & ~hold_off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      cs_q     <= 1'b1;
      pend_vld <= 1'b0;
      pend_q   <= '0;
      word_q   <= '0;
    end else begin
      busy_q <= busy;
      cs_q   <= cs_n;
      if (take_new) begin
        word_q   <= result;
        pend_vld <= 1'b0;
      end else if (busy_fall) begin
        pend_q   <= result;
        pend_vld <= 1'b1;
      end else if (cs_rise && pend_vld) begin
        word_q   <= pend_q;
        pend_vld <= 1'b0;
      end
    end
  end

  always_comb begin
    load_en   = take_new | cs_rise;
    load_data = word_q;
    if (take_new)      load_data = result;
    else if (pend_vld) load_data = pend_q;
  end

  assign err_d = (mode == RD_DURING) & busy_fall & ~cs_n &
                 (bit_cnt != '0) & (bit_cnt < FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign rd_err = err_q;
endmodule

// File: rtl/rd_shift_core.sv
module rd_shift_core #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_data,
  input  logic              shift_go,
  input  logic              latch_go,
  input  logic              chain_use,
  input  logic              chain_in,
  output logic              msb,
  output logic [CNT_W-1:0]  bit_cnt
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  logic [DATA_W-1:0] sr_q;
  logic              chain_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= 1'b0;
    end else if (latch_go) begin
      chain_q <= chain_use & chain_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (load_en) begin
      sr_q <= load_data;
    end else if (shift_go) begin
      sr_q <= {sr_q[DATA_W-2:0], chain_q};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || cs_n) begin
      cnt_q <= '0;
    end else if (shift_go && cnt_q < FULL) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign msb     = sr_q[DATA_W-1];
  assign bit_cnt = cnt_q;
endmodule

// File: rtl/adc_serial_rd.sv
module adc_serial_rd
  import adc_rd_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode,
  input  logic              busy,
  input  logic [DATA_W-1:0] result,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              sclk,
  input  logic              chain_in,
  output logic              sdout,
  output logic              sdout_en,
  output logic              rd_err
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  rd_mode_e          mode_e;
  logic              s_rise, s_fall;
  logic              load_en;
  logic [DATA_W-1:0] load_data;
  logic [CNT_W-1:0]  bit_cnt;
  logic              msb, sel, may_shift, shift_go, latch_go;

  assign mode_e    = rd_mode_e'(mode);
  assign sel       = ~cs_n & ~rd_n;
  assign may_shift = (mode_e == RD_DURING) | ~busy | (bit_cnt != '0);
  assign shift_go  = s_fall & sel & may_shift;
  assign latch_go  = s_rise & sel;

  sclk_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .sclk (sclk),
    .rise (s_rise),
    .fall (s_fall)
  );

  rd_load_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_load (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode_e),
    .busy     (busy),
    .result   (result),
    .cs_n     (cs_n),
    .bit_cnt  (bit_cnt),
    .load_en  (load_en),
    .load_data(load_data),
    .rd_err   (rd_err)
  );

  rd_shift_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .load_en  (load_en),
    .load_data(load_data),
    .shift_go (shift_go),
    .latch_go (latch_go),
    .chain_use(mode_e == RD_AFTER),
    .chain_in (chain_in),
    .msb      (msb),
    .bit_cnt  (bit_cnt)
  );

  assign sdout_en = ~cs_n;
  assign sdout    = sdout_en & msb;
endmodule

// File: rtl/adc_serial_rd_chk.sv
module adc_serial_rd_chk (
  input logic clk,
  input logic rst_n,
  input logic mode,
  input logic busy,
  input logic cs_n,
  input logic rd_n,
  input logic sdout,
  input logic rd_err
);
  // R8
  rd_err_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |=> !rd_err);

  // R8
  rd_err_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> $past(mode) && !$past(cs_n));

  // R8
  rd_err_busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> (!$past(busy) && $past(busy, 2)));

  // R2
  sdout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$past(cs_n) && rd_n && $stable(busy)) |=> $stable(sdout));
endmodule

bind adc_serial_rd adc_serial_rd_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .mode  (mode),
  .busy  (busy),
  .cs_n  (cs_n),
  .rd_n  (rd_n),
  .sdout (sdout),
  .rd_err(rd_err)
);

// File: tb/adc_serial_rd_tb.sv
module adc_serial_rd_tb;
  localparam int H = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b0, busy = 1'b0, cs_n = 1'b1, rd_n = 1'b1, sclk = 1'b0;
  logic        up_chain = 1'b1;
  logic [15:0] res_dn = '0, res_up = '0;
  logic        dn_out, dn_en, dn_err, up_out, up_en, up_err;
  int          errors = 0, checks = 0, err_pulses = 0;
  logic [63:0] got;

  always #5 clk = ~clk;

  adc_serial_rd u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .busy(busy), .result(res_dn),
    .cs_n(cs_n), .rd_n(rd_n), .sclk(sclk), .chain_in(up_out),
    .sdout(dn_out), .sdout_en(dn_en), .rd_err(dn_err));

  adc_serial_rd u_up (
    .clk(clk), .rst_n(rst_n), .mode(mode), .busy(busy), .result(res_up),
    .cs_n(cs_n), .rd_n(rd_n), .sclk(sclk), .chain_in(up_chain),
    .sdout(up_out), .sdout_en(up_en), .rd_err(up_err));

  always @(posedge clk) if (rst_n && dn_err) err_pulses++;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [63:0] cascade_exp(input logic [15:0] dn, input logic [15:0] up);
    return {32'h0, dn, up};
  endfunction

  task automatic convert(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    res_dn = a; res_up = b; busy = 1'b1;
    wait_n(8);
    busy = 1'b0;
    wait_n(4);
  endtask

  task automatic open_read(input logic rd);
    @(negedge clk);
    cs_n = 1'b0; rd_n = rd;
    wait_n(H);
  endtask

  task automatic close_read();
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
    wait_n(H);
  endtask

  task automatic clock_bits(input int n);
    got = '0;
    for (int i = 0; i < n; i++) begin
      got = {got[62:0], dn_out};
      sclk = 1'b1;
      wait_n(H);
      sclk = 1'b0;
      wait_n(H);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] a, b, c, d;
    int unsigned seed;
    seed = $urandom(32'h5eed);
    wait_n(4);
    // R1 / R3: reset state
    check("R1 sdout_en", {63'h0, dn_en}, 64'h0);
    check("R1 rd_err", {62'h0, dn_err, dn_out}, 64'h0);
    rst_n = 1'b1;
    wait_n(4);

    // R6 / R2 / R4: random cascade reads in read-after mode
    mode = 1'b0;
    for (int k = 0; k < 6; k++) begin
      a = 16'($urandom); b = 16'($urandom);
      if (k == 0) begin a = 16'h8001; b = 16'hFFFE; end
      convert(a, b);
      open_read(1'b0);
      clock_bits(32);
      check("R6 cascade", got, cascade_exp(a, b));
      close_read();
    end

    // R3: idle with cs_n high
    check("R3 idle drive", {62'h0, dn_en, dn_out}, 64'h0);
    open_read(1'b0);
    check("R3 enabled", {63'h0, dn_en}, 64'h1);
    close_read();

    // R2: sclk with rd_n high does not advance
    a = 16'h5A3C;
    convert(a, 16'h0);
    open_read(1'b1);
    clock_bits(3);
    @(negedge clk); rd_n = 1'b0; wait_n(H);
    clock_bits(16);
    check("R2 rd_n gating", got, {48'h0, a});
    close_read();

    // R4: no shift may begin while busy is high
    @(negedge clk); res_dn = 16'h1234; busy = 1'b1;
    open_read(1'b0);
    clock_bits(4);
    check("R4 blocked while busy", got, {60'h0, {4{a[15]}}});
    close_read();
    @(negedge clk); busy = 1'b0; wait_n(4);
    open_read(1'b0);
    clock_bits(16);
    check("R4 new word after busy", got, 64'h1234);
    close_read();

    // R5: conversion ends mid-read in read-after mode
    a = 16'($urandom); b = 16'($urandom);
    convert(a, 16'h0);
    open_read(1'b0);
    clock_bits(8);
    c = got[15:0];
    @(negedge clk); res_dn = b; busy = 1'b1; wait_n(8);
    busy = 1'b0; wait_n(4);
    clock_bits(8);
    check("R5 word kept", {48'h0, c[7:0], got[7:0]}, {48'h0, a});
    check("R8 no error in mode 0", err_pulses, 0);
    close_read();
    open_read(1'b0);
    clock_bits(16);
    check("R5 deferred word", got, {48'h0, b});
    close_read();

    // R9: abandon and restart
    open_read(1'b0);
    clock_bits(5);
    close_read();
    open_read(1'b0);
    clock_bits(16);
    check("R9 restart from MSB", got, {48'h0, b});
    close_read();

    // Read-during mode
    mode = 1'b1;
    for (int k = 0; k < 3; k++) begin
      c = 16'($urandom); d = 16'($urandom);
      convert(c, 16'($urandom));
      err_pulses = 0;
      @(negedge clk); res_dn = d; busy = 1'b1;
      open_read(1'b0);
      clock_bits(32);
      check("R7 chain ignored", got, {32'h0, c, 16'h0});
      close_read();
      @(negedge clk); busy = 1'b0; wait_n(4);
      check("R8 full read no error", err_pulses, 0);

      @(negedge clk); res_dn = 16'($urandom); busy = 1'b1;
      open_read(1'b0);
      clock_bits(5);
      check("R8 short read bits", got, {59'h0, d[15:11]});
      @(negedge clk); busy = 1'b0; wait_n(4);
      check("R8 error pulse", err_pulses, 1);
      close_read();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule